// File: doc/BRIEF.md
# Dual-Client Bus Master Request Arbiter

This block decides which of four FIFO-side request lines gets the bus master next. A receive DMA client and a transmit DMA client each own a read FIFO and a write FIFO, and each FIFO raises its own request line. The arbiter records the order in which requests appear and serves them first come, first served. When several requests appear in the same cycle, the receive side wins the tie.

A grant stays on one line until the bus sequencer pulses `xfer_done`. On that pulse the arbiter takes the oldest pending request. If the external bus grant is still held at that moment, it flags the new grant with `keep_bus_o`. The sequencer then keeps ownership of the bus and inserts a single idle bus cycle, rather than releasing the bus and arbitrating for it again.

Request bit mapping (index = tie-break rank, lowest first): bit 0 receive read, bit 1 receive write, bit 2 transmit read, bit 3 transmit write.

Top module: `busm_arbiter`

## Requirements
- R1: After synchronous reset, `grant_o` is 0, `grant_vld_o` is 0, `keep_bus_o` is 0 and no request is pending.
- R2: Requests are granted in the order in which they were first sampled high, independent of their index.
- R3: Requests first sampled high on the same clock edge are granted in ascending bit index: receive read (bit 0), receive write (bit 1), transmit read (bit 2), transmit write (bit 3).
- R4: When the arbiter is idle with nothing pending, a request first sampled on edge N is not yet granted after edge N, and is granted after edge N+1.
- R5: While `xfer_done` is low, `grant_o` and `grant_vld_o` do not change, even if new requests arrive.
- R6: When `xfer_done` is sampled high with a request pending, the oldest pending request is granted after that same edge. If nothing is pending, `grant_vld_o` and `grant_o` go to 0.
- R7: `keep_bus_o` is 1 exactly while a grant is held that was issued on an `xfer_done` edge at which `bus_gnt_i` was high and the previous grant was valid. Otherwise it is 0.
- R8: All four request lines raised at once are all queued, and each is granted exactly once.
- R9: A line that stays high while queued or granted is not queued a second time. A line still high on the first edge after its grant has ended is queued again as a new arrival behind older requests.
- R10: `xfer_done` has no effect while no grant is valid.
- R11: `grant_o` has at most one bit set, and exactly one whenever `grant_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ | Request lines, bit mapping as above |
| xfer_done | input | 1 | One-cycle pulse: granted transfer finished |
| bus_gnt_i | input | 1 | External bus grant is still asserted |
| grant_o | output | NUM_REQ | One-hot grant |
| grant_vld_o | output | 1 | A grant is held |
| keep_bus_o | output | 1 | Current grant follows back-to-back on a held bus |

## Verification
The hardest situation to reach from the ports is one where the arrival queue holds requests from two different edges. In that case same-edge ordering and cross-edge ordering must both be honoured, while the grant, the queue pop and new pushes all happen on one edge. The bench sweeps every nonempty first batch against every disjoint second batch raised one edge later. It then retires the grants with `bus_gnt_i` alternating. A directed sequence keeps a granted line high through and after its completion so that the re-arrival path is exercised.

// File: rtl/busm_pkg.sv
package busm_pkg;
  localparam int BUSM_NREQ = 4;

  typedef enum logic [1:0] {
    SRC_RX_RD = 2'd0,
    SRC_RX_WR = 2'd1,
    SRC_TX_RD = 2'd2,
    SRC_TX_WR = 2'd3
  } busm_src_e;
endpackage

// File: rtl/busm_arrival.sv
module busm_arrival #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] queued_i,
  input  logic [NUM_REQ-1:0] granted_i,
  output logic [NUM_REQ-1:0] push_o
);
  logic [NUM_REQ-1:0] busy;

  always_comb begin
    busy   = queued_i | granted_i;
    push_o = req_i & ~busy;
  end

  AST_GRANT_NOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
    (granted_i & queued_i) == '0);  // R9
endmodule

// File: rtl/busm_order_q.sv
module busm_order_q #(
  parameter int NUM_REQ = 4,
  localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CNT_W = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] push_i,
  input  logic               pop_i,
  output logic [ID_W-1:0]    head_o,
  output logic               empty_o,
  output logic [NUM_REQ-1:0] member_o
);
  logic [ID_W-1:0]  ent   [NUM_REQ];
  logic [ID_W-1:0]  ent_n [NUM_REQ];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    int pos;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (pop_i && (i < NUM_REQ - 1)) ent_n[i] = ent[i+1];
      else if (pop_i)                 ent_n[i] = '0;
      else                            ent_n[i] = ent[i];
    end
    pos = int'(cnt) - (pop_i ? 1 : 0);
    for (int k = 0; k < NUM_REQ; k++) begin
      if (push_i[k] && (pos < NUM_REQ)) begin
        ent_n[pos] = ID_W'(k);
        pos = pos + 1;
      end
    end
    cnt_n = CNT_W'(pos);
  end

  always_comb begin
    member_o = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (i < int'(cnt)) member_o[ent[i]] = 1'b1;
    end
  end

  assign head_o  = ent[0];
  assign empty_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int i = 0; i < NUM_REQ; i++) ent[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < NUM_REQ; i++) ent[i] <= ent_n[i];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= NUM_REQ);  // R8
  AST_UNIQUE_IDS: assert property (@(posedge clk) disable iff (rst)
    $countones(member_o) == int'(cnt));  // R9
  AST_PUSH_FRESH: assert property (@(posedge clk) disable iff (rst)
    (push_i & member_o) == '0);  // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);  // R6
endmodule

// File: rtl/busm_grant_ctl.sv
module busm_grant_ctl #(
  parameter int NUM_REQ = 4,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xfer_done,
  input  logic               bus_gnt_i,
  input  logic               q_empty_i,
  input  logic [ID_W-1:0]    q_head_i,
  output logic               pop_o,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               grant_vld_o,
  output logic               keep_bus_o
);
  logic finish;

  always_comb begin
    finish = grant_vld_o && xfer_done;
    pop_o  = (!grant_vld_o || finish) && !q_empty_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= '0;
      grant_vld_o <= 1'b0;
      keep_bus_o  <= 1'b0;
    end else if (pop_o) begin
      grant_o     <= NUM_REQ'(1) << q_head_i;
      grant_vld_o <= 1'b1;
      keep_bus_o  <= finish && bus_gnt_i;
    end else if (finish) begin
      grant_o     <= '0;
      grant_vld_o <= 1'b0;
      keep_bus_o  <= 1'b0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));  // R11
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (grant_vld_o && !xfer_done) |=> ($stable(grant_o) && grant_vld_o));  // R5
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (grant_vld_o && xfer_done && q_empty_i) |=> !grant_vld_o);  // R6
  AST_KEEP_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    keep_bus_o |-> grant_vld_o);  // R7
  AST_DONE_IGNORED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld_o && q_empty_i) |=> !grant_vld_o);  // R10
endmodule

// File: rtl/busm_arbiter.sv
module busm_arbiter #(
  parameter int NUM_REQ = busm_pkg::BUSM_NREQ,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               xfer_done,
  input  logic               bus_gnt_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               grant_vld_o,
  output logic               keep_bus_o
);
  logic [NUM_REQ-1:0] push;
  logic [NUM_REQ-1:0] member;
  logic [ID_W-1:0]    head;
  logic               q_empty;
  logic               pop;

  busm_arrival #(.NUM_REQ(NUM_REQ)) u_arrival (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .queued_i  (member),
    .granted_i (grant_o),
    .push_o    (push)
  );

  busm_order_q #(.NUM_REQ(NUM_REQ)) u_order_q (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push),
    .pop_i    (pop),
    .head_o   (head),
    .empty_o  (q_empty),
    .member_o (member)
  );

  busm_grant_ctl #(.NUM_REQ(NUM_REQ)) u_grant_ctl (
    .clk         (clk),
    .rst         (rst),
    .xfer_done   (xfer_done),
    .bus_gnt_i   (bus_gnt_i),
    .q_empty_i   (q_empty),
    .q_head_i    (head),
    .pop_o       (pop),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o),
    .keep_bus_o  (keep_bus_o)
  );

  AST_HEAD_NOT_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (pop && grant_vld_o && !xfer_done) == 1'b0);  // R5
endmodule

// File: tb/test_busm_arbiter.sv
`timescale 1ns/1ps
module test_busm_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic         bgnt = 1'b0;
  logic [N-1:0] grant;
  logic         vld;
  logic         keep;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  busm_arbiter #(.NUM_REQ(N)) i_busm_arbiter (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .xfer_done   (done),
    .bus_gnt_i   (bgnt),
    .grant_o     (grant),
    .grant_vld_o (vld),
    .keep_bus_o  (keep)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_id [4];
    int n;
    int na;
    bit expkeep;
    string tag;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grant", int'(grant), 0);
    chk("R1 vld", int'(vld), 0);
    chk("R1 keep", int'(keep), 0);

    for (int a = 1; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if ((a & b) != 0) continue;
        n = 0;
        for (int i = 0; i < N; i++) if (a[i]) begin exp_id[n] = i; n++; end
        na = n;
        for (int i = 0; i < N; i++) if (b[i]) begin exp_id[n] = i; n++; end
        if (a == 15) tag = "R8";
        else if (na > 1) tag = "R3";
        else tag = "R2";

        req = N'(a);
        @(negedge clk);
        chk("R4 not yet", int'(vld), 0);
        req = N'(a | b);
        @(negedge clk);
        expkeep = 1'b0;
        for (int j = 0; j < n; j++) begin
          chk(tag, int'(grant), 1 << exp_id[j]);
          chk("R11", $countones(grant), 1);
          chk("R7", int'(keep), int'(expkeep));
          if ((j % 2) == 0) begin
            @(negedge clk);
            chk("R5", int'(grant), 1 << exp_id[j]);
          end
          done = 1'b1;
          bgnt = ((a + b + j) % 2) == 1;
          req[exp_id[j]] = 1'b0;
          expkeep = bgnt && (j + 1 < n);
          @(negedge clk);
          done = 1'b0;
          bgnt = 1'b0;
        end
        chk("R6 idle", int'(vld), 0);
        chk("R7 idle", int'(keep), 0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        chk("R10 vld", int'(vld), 0);
        chk("R10 grant", int'(grant), 0);
      end
    end

    req = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    chk("R9 first", int'(grant), 1);
    req = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R9 held", int'(grant), 1);
    done = 1'b1;
    bgnt = 1'b1;
    @(negedge clk);
    done = 1'b0;
    bgnt = 1'b0;
    chk("R9 next", int'(grant), 2);
    chk("R7 chained", int'(keep), 1);
    req = 4'b0001;
    @(negedge clk);
    req = 4'b0000;
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R9 requeue", int'(grant), 1);
    chk("R7 bus dropped", int'(keep), 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no duplicate", int'(vld), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule